// File: doc/BRIEF.md
# Block Memory Transfer Engine

This block copies a run of bytes from one place in memory to another. It is given a source pointer, a destination pointer, a 16-bit byte count and a two-bit addressing style. It then steps through the run on a simple synchronous memory port. For each byte it issues one read cycle and one write cycle. A third cycle then advances the pointers and lowers the count.

Two of the styles move both pointers together, either upward or downward. The other two hold one pointer still, so that a peripheral data port can be fed from memory or drained into memory. When the run ends, the block pulses `done`. The pointer and count outputs then hold their final values, ready to be written back into the register file. Opcode decoding, interruption of a run and bus arbitration are handled outside the block.

Top module: `bmt_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_re` and `mem_we` are low and `src_out`, `dst_out` and `cnt_out` are zero.
- R2: `start` is accepted only while the engine is idle (not busy and not pulsing `done`). On acceptance, `mode`, `src_in`, `dst_in` and `cnt_in` are captured. A `start` raised while a run is in progress has no effect on that run's memory traffic, timing or results.
- R3: After an accepted `start` with count n, `busy` is high for exactly SETUP_CYC + 3*n cycles (SETUP_CYC defaults to 6). In the following cycle `done` is high for exactly one cycle and `busy` is low.
- R4: Each byte takes three cycles in a fixed order:
  - a read cycle, with `mem_re` high and `mem_addr` equal to the source pointer;
  - a write cycle, with `mem_we` high, `mem_addr` equal to the destination pointer and `mem_wdata` equal to the `mem_rdata` returned one cycle after the read;
  - an update cycle with no memory access.
- R5: Mode value 0 advances both the source and the destination pointer by +1 after each byte.
- R6: Mode value 1 advances both the source and the destination pointer by -1 after each byte.
- R7: Mode value 2 advances the source by +1 after each byte and holds the destination fixed.
- R8: Mode value 3 holds the source fixed and advances the destination by +1 after each byte.
- R9: The count output drops by one in each update cycle. While `done` is high, `cnt_out` is 0, and `src_out` and `dst_out` equal the start pointers advanced n times under the selected mode.
- R10: A count of zero causes no memory access. `done` then follows after the SETUP_CYC setup cycles alone.
- R11: Pointer arithmetic wraps modulo 2^AW in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run |
| mode | input | 2 | Addressing style (0 both up, 1 both down, 2 source up, 3 destination up) |
| src_in | input | AW | Initial source pointer |
| dst_in | input | AW | Initial destination pointer |
| cnt_in | input | CW | Number of bytes to move |
| mem_addr | output | AW | Memory address for the current access |
| mem_re | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after mem_re |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | AW | Current or final source pointer |
| dst_out | output | AW | Current or final destination pointer |
| cnt_out | output | CW | Current or remaining byte count |

## Verification
The bench builds the engine with AW = 10 and keeps CW = 16 and SETUP_CYC = 6. The narrow address gives a 1024-byte memory model that the bench can mirror in full. It also puts both ends of the address space within a few bytes of ordinary runs, so wrap-around in the upward and downward directions is exercised by short transfers. All four addressing styles, the zero-length run and a `start` raised in the middle of a run are covered. In each case the read/write address stream is checked against a reference copy of memory.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

  typedef enum logic [1:0] {
    XM_UP        = 2'd0,
    XM_DOWN      = 2'd1,
    XM_TO_PORT   = 2'd2,
    XM_FROM_PORT = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RD,
    ST_WR,
    ST_UPD,
    ST_FIN
  } seq_state_e;

  // Next pointer value after one byte, for source (is_src=1) or destination.
  function automatic logic [31:0] advance(input logic [31:0] p,
                                          input xfer_mode_e m,
                                          input logic is_src);
    logic [31:0] r;
    case (m)
      XM_UP:        r = p + 32'd1;
      XM_DOWN:      r = p - 32'd1;
      XM_TO_PORT:   r = is_src ? p + 32'd1 : p;
      default:      r = is_src ? p : p + 32'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bmt_ptr.sv
module bmt_ptr
  import bmt_pkg::*;
#(
  parameter int AW     = 16,
  parameter bit IS_SRC = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  xfer_mode_e    mode,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (step)  ptr <= AW'(advance(32'(ptr), mode, IS_SRC));
  end

endmodule

// File: rtl/bmt_seq.sv
module bmt_seq
  import bmt_pkg::*;
#(
  parameter int CW        = 16,
  parameter int SETUP_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  output logic          accept,
  output logic          rd_ev,
  output logic          wr_ev,
  output logic          upd_ev,
  output logic          fin_ev,
  output logic          busy,
  output logic [CW-1:0] cnt
);

  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_CYC - 1);

  seq_state_e    state;
  logic [SW-1:0] setup_ctr;

  assign accept = start && (state == ST_IDLE);
  assign rd_ev  = (state == ST_RD);
  assign wr_ev  = (state == ST_WR);
  assign upd_ev = (state == ST_UPD);
  assign fin_ev = (state == ST_FIN);
  assign busy   = (state == ST_SETUP) || rd_ev || wr_ev || upd_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      setup_ctr <= '0;
      cnt       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_SETUP;
          setup_ctr <= '0;
          cnt       <= cnt_in;
        end
        ST_SETUP: begin
          setup_ctr <= setup_ctr + 1'b1;
          if (setup_ctr == SETUP_LAST)
            state <= (cnt == '0) ? ST_FIN : ST_RD;
        end
        ST_RD:  state <= ST_WR;
        ST_WR:  state <= ST_UPD;
        ST_UPD: begin
          cnt   <= cnt - 1'b1;
          state <= (cnt == CW'(1)) ? ST_FIN : ST_RD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bmt_engine.sv
module bmt_engine
  import bmt_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CW        = 16,
  parameter int SETUP_CYC = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [CW-1:0] cnt_out
);

  localparam int NPTR = 2;

  logic accept, rd_ev, wr_ev, upd_ev, fin_ev;
  xfer_mode_e    mode_q;
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_cur  [NPTR];

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= XM_UP;
    else if (accept) mode_q <= xfer_mode_e'(mode);
  end

  bmt_seq #(.CW(CW), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_in),
    .accept(accept), .rd_ev(rd_ev), .wr_ev(wr_ev), .upd_ev(upd_ev),
    .fin_ev(fin_ev), .busy(busy), .cnt(cnt_out)
  );

  assign ptr_init[0] = src_in;
  assign ptr_init[1] = dst_in;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    bmt_ptr #(.AW(AW), .IS_SRC(g == 0)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(ptr_init[g]),
      .step(upd_ev), .mode(mode_q), .ptr(ptr_cur[g])
    );
  end

  assign src_out   = ptr_cur[0];
  assign dst_out   = ptr_cur[1];
  assign mem_re    = rd_ev;
  assign mem_we    = wr_ev;
  assign mem_addr  = wr_ev ? ptr_cur[1] : ptr_cur[0];
  assign mem_wdata = mem_rdata;
  assign done      = fin_ev;

endmodule

// File: rtl/bmt_engine_chk.sv
module bmt_engine_chk
  import bmt_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_re,
  input logic          mem_we,
  input logic          upd_ev,
  input xfer_mode_e    mode_q,
  input logic [AW-1:0] src_out,
  input logic [AW-1:0] dst_out,
  input logic [CW-1:0] cnt_out
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !mem_we));

  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_mode_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mode_q));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ev |=> (cnt_out == $past(cnt_out) - CW'(1)));

  p_count_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_out == '0));

  p_dst_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ev && mode_q == XM_TO_PORT) |=> $stable(dst_out));

  p_src_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ev && mode_q == XM_FROM_PORT) |=> $stable(src_out));

endmodule

bind bmt_engine bmt_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_re(mem_re), .mem_we(mem_we), .upd_ev(upd_ev), .mode_q(mode_q),
  .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
);

// File: tb/sim_bmt_engine.sv
module sim_bmt_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int SETUP = 6;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [AW-1:0] src_in = '0, dst_in = '0;
  logic [CW-1:0] cnt_in = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_re, mem_we, busy, done;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] rdata_q = '0;
  logic [AW-1:0] src_out, dst_out;
  logic [CW-1:0] cnt_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmt_engine #(.AW(AW), .DW(DW), .CW(CW), .SETUP_CYC(SETUP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
    .busy(busy), .done(done),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
  );

  logic [DW-1:0] mem     [MSZ];
  logic [DW-1:0] ref_mem [MSZ];

  always @(posedge clk) begin
    rdata_q <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  typedef struct { bit wr; int addr; int data; } item_t;
  item_t sbq[$];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected memory accesses as the design produces them (R4).
  always @(negedge clk) begin
    if (rst_n && (mem_re || mem_we)) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R4", "unexpected access addr", int'(mem_addr), -1);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(it.wr == mem_we, "R4", "access kind write", int'(mem_we), int'(it.wr));
        chk(int'(mem_addr) == it.addr, "R4", "access address", int'(mem_addr), it.addr);
        if (it.wr)
          chk(int'(mem_wdata) == it.data, "R4", "write data", int'(mem_wdata), it.data);
      end
    end
  end

  function automatic int nxt(input int p, input int m, input bit is_src);
    int d;
    if (m == 0) d = 1;
    else if (m == 1) d = -1;
    else if (m == 2) d = is_src ? 1 : 0;
    else d = is_src ? 0 : 1;
    return (p + d + MSZ) % MSZ;
  endfunction

  // Driver: pushes expectations, runs a transfer, checks timing and results.
  task automatic run(input int m, input int s0, input int d0, input int n,
                     input bit poke, input string mreq);
    int s = s0, d = d0, busy_cnt = 0, guard = 0;
    bit saw_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      sbq.push_back('{wr: 1'b0, addr: s, data: 0});
      sbq.push_back('{wr: 1'b1, addr: d, data: int'(ref_mem[s])});
      ref_mem[d] = ref_mem[s];
      s = nxt(s, m, 1'b1);
      d = nxt(d, m, 1'b0);
    end
    @(negedge clk);
    start = 1'b1; mode = 2'(m); src_in = AW'(s0); dst_in = AW'(d0); cnt_in = CW'(n);
    @(negedge clk);
    start = 1'b0; src_in = '0; dst_in = '0; cnt_in = '0; mode = 2'd0;
    while (!saw_done && guard < 400000) begin
      guard++;
      if (busy) busy_cnt++;
      if (done) begin
        saw_done = 1'b1;
        chk(!busy, "R3", "busy low at done", int'(busy), 0);
        chk(cnt_out == '0, "R9", "final count", int'(cnt_out), 0);
        chk(int'(src_out) == s, mreq, "final source", int'(src_out), s);
        chk(int'(dst_out) == d, mreq, "final destination", int'(dst_out), d);
      end else begin
        if (poke && busy_cnt == 4) begin
          start = 1'b1; mode = 2'd1; src_in = AW'(7); dst_in = AW'(9); cnt_in = CW'(2);
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk(saw_done, "R3", "done seen", int'(saw_done), 1);
    chk(busy_cnt == SETUP + 3*n, "R3", "busy cycles", busy_cnt, SETUP + 3*n);
    @(negedge clk);
    chk(!done, "R3", "done one cycle", int'(done), 0);
    chk(sbq.size() == 0, "R4", "leftover expected accesses", sbq.size(), 0);
    sbq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = DW'(i * 37 + 11);
      ref_mem[i] = DW'(i * 37 + 11);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1", "busy/done after reset", int'({busy, done}), 0);
    chk(!mem_re && !mem_we, "R1", "strobes after reset", int'({mem_re, mem_we}), 0);
    chk(src_out == '0 && dst_out == '0 && cnt_out == '0, "R1", "outputs after reset",
        int'(src_out) + int'(dst_out) + int'(cnt_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 16, 200, 4, 1'b0, "R5");          // both up
    run(1, 300, 500, 3, 1'b0, "R6");         // both down
    run(2, 40, 700, 5, 1'b0, "R7");          // source up, destination fixed
    run(3, 60, 800, 4, 1'b0, "R8");          // source fixed, destination up
    run(0, 100, 900, 0, 1'b0, "R10");        // zero count: no accesses
    run(0, 120, 600, 6, 1'b1, "R2");         // start raised mid-run is ignored
    run(0, 1022, 400, 4, 1'b0, "R11");       // upward wrap of source
    run(1, 450, 1, 3, 1'b0, "R11");          // downward wrap of destination
    run(2, 1023, 850, 2, 1'b0, "R11");       // wrap with fixed destination
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule